// File: doc/BRIEF.md
# Frame-Sync Halfword Serial Transmitter

This block drains 16-bit halfwords from a transmit FIFO and sends each of them as two bytes on a single serial data line. A byte leaves only when the transmit frame sync is asserted: after the sync is sampled, the eight following bit clocks carry that byte, most significant bit first. Because one sync moves one byte while the FIFO holds two-byte entries, the block remembers across sync pulses whether the upper or the lower byte of the FIFO head goes out next. The head entry is popped only when its lower byte has finished.

The FIFO is read in first-word-fall-through fashion: `fifo_data` shows the head entry whenever `fifo_empty` is low. Entries are 32-bit bus words, and only bits 15:0 are used. If a sync arrives while the FIFO is empty, the block sends a zero byte and raises a sticky underflow flag. The transmit sync is independent of any receive timing, so the block relies on nothing beyond its own sync line.

Top module: `fs_hw_tx`

## Requirements
- R1: After reset `sdata`, `fifo_pop` and `underflow` are all 0.
- R2: A sync sampled high at a clock edge while no byte is in flight starts a byte. Its bits appear on `sdata` in the eight cycles that follow that edge, bit 7 first and bit 0 last.
- R3: For each FIFO entry, the first byte sent is bits 15:8 and the byte on the next sync is bits 7:0.
- R4: `fifo_pop` is high for exactly one cycle per entry. That cycle is the one that carries bit 0 of the entry's lower byte. It is never high during an upper byte.
- R5: Bits 31:16 of `fifo_data` have no effect on the serial output.
- R6: A sync that is sampled while a byte is in flight is ignored. The byte in flight completes unchanged, and no extra byte follows.
- R7: A sync that starts a byte while `fifo_empty` is high sends eight zero bits, does not pop, and does not advance the upper/lower position. It also sets `underflow`, which then stays at 1 until reset.
- R8: `sdata` is 0 in every cycle in which no byte is in flight.
- R9: `fifo_pop` is never high while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Transmit frame sync, sampled on the rising edge |
| fifo_empty | input | 1 | FIFO has no entry |
| fifo_data | input | 32 | FIFO head entry (bits 15:0 used) |
| sdata | output | 1 | Serial data out |
| fifo_pop | output | 1 | Removes the FIFO head on the next rising edge |
| underflow | output | 1 | Sticky flag: a byte was requested from an empty FIFO |

## Verification
The assertions assume a FIFO that holds its head entry steady and reports `fifo_empty` truthfully until it sees a pop. They also assume that syncs are single-cycle pulses. The bench models the FIFO with a queue that changes only on pops and on pushes made between bytes. Each sync pulse lasts one cycle, and a new pulse is issued only after the previous byte has completed. The one exception is the deliberate mid-byte pulse that exercises R6.

// File: rtl/fs_hw_tx.sv
module fs_hw_tx #(
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             fifo_empty,
  input  logic [BUS_W-1:0] fifo_data,
  output logic             sdata,
  output logic             fifo_pop,
  output logic             underflow
);
  localparam int HW_W  = 2 * BYTE_W;
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              busy, low_next, cur_low, cur_fifo;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;

  wire start = fsync && !busy;
  wire have  = !fifo_empty;
  wire [BYTE_W-1:0] pick = low_next ? fifo_data[BYTE_W-1:0] : fifo_data[HW_W-1:BYTE_W];
  wire unused_hi = ^fifo_data[BUS_W-1:HW_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      low_next  <= 1'b0;
      cur_low   <= 1'b0;
      cur_fifo  <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      underflow <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= '0;
      sh       <= have ? pick : '0;
      cur_fifo <= have;
      cur_low  <= low_next;
      if (have) low_next  <= ~low_next;
      else      underflow <= 1'b1;
    end else if (busy) begin
      sh  <= {sh[BYTE_W-2:0], 1'b0};
      cnt <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  assign sdata    = busy & sh[BYTE_W-1];
  assign fifo_pop = busy && (cnt == LAST) && cur_low && cur_fifo;
endmodule

module fs_hw_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic fsync,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic sdata,
  input logic underflow,
  input logic busy
);
  // R9
  pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R7
  underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && !busy && fifo_empty) |=> underflow);
  // R4
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);
  // R8
  idle_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !sdata);
  // R2
  start_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && !busy) |=> busy);
endmodule

bind fs_hw_tx fs_hw_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .fifo_empty(fifo_empty),
  .fifo_pop(fifo_pop), .sdata(sdata), .underflow(underflow), .busy(busy)
);

// File: tb/fs_hw_tx_test.sv
module fs_hw_tx_test;
  logic        clk = 0, rst_n = 0, fsync = 0, fifo_empty = 1;
  logic [31:0] fifo_data = '0;
  logic        sdata, fifo_pop, underflow;

  int checks = 0, errors = 0, pops_seen = 0, pushes = 0;
  logic [31:0] fq[$];
  logic [31:0] mq[$];
  logic        m_low = 0;
  logic [8:0]  expq[$];
  bit          done = 0;

  always #10 clk = ~clk;

  fs_hw_tx uut (.clk(clk), .rst_n(rst_n), .fsync(fsync), .fifo_empty(fifo_empty),
                .fifo_data(fifo_data), .sdata(sdata), .fifo_pop(fifo_pop),
                .underflow(underflow));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (fifo_pop && fq.size() > 0) void'(fq.pop_front());
  always @(negedge clk) begin
    fifo_empty = (fq.size() == 0);
    fifo_data  = fifo_empty ? 32'h0 : fq[0];
  end

  task automatic push(logic [31:0] w);
    @(negedge clk);
    fq.push_back(w);
    mq.push_back(w);
    pushes++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(bit extra_sync);
    logic [7:0] b;
    logic       p;
    @(negedge clk);
    if (mq.size() == 0) begin b = 8'h00; p = 0; end
    else begin
      b = m_low ? mq[0][7:0] : mq[0][15:8];
      p = m_low;
      if (m_low) void'(mq.pop_front());
      m_low = ~m_low;
    end
    expq.push_back({p, b});
    fsync = 1;
    @(negedge clk);
    fsync = 0;
    if (extra_sync) begin
      repeat (3) @(negedge clk);
      fsync = 1;
      @(negedge clk);
      fsync = 0;
    end
    repeat (10) @(negedge clk);
    check("R8 idle sdata", sdata, 0);
  endtask

  initial begin : monitor
    logic [7:0] got;
    logic       pop_last;
    forever begin
      @(posedge clk);
      if (rst_n && fsync) begin
        for (int i = 0; i < 8; i++) begin
          @(negedge clk);
          got = {got[6:0], sdata};
          if (fifo_pop) pops_seen++;
          if (i < 7) check("R4 no early pop", fifo_pop, 0);
          pop_last = fifo_pop;
        end
        if (expq.size() == 0) check("R6 unexpected byte", 1, 0);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          check("R2 R3 R5 byte", got, e[7:0]);
          check("R4 pop on last bit", pop_last, e[8]);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sdata", sdata, 0);
    check("R1 pop", fifo_pop, 0);
    check("R1 underflow", underflow, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R3 R5: upper bits are garbage
    push(32'hDEAD_1234);
    send(0); send(0);
    check("R9 fifo drained", fq.size(), 0);
    push(32'h0000_A55A);
    push(32'hFFFF_00FF);
    send(0); send(0); send(0); send(0);
    // R6: extra sync mid-byte
    push(32'h5A5A_C381);
    send(1); send(1);
    check("R6 no stray byte", expq.size(), 0);
    check("R7 no underflow yet", underflow, 0);
    // R7: empty FIFO
    send(0);
    check("R7 underflow set", underflow, 1);
    push(32'h0000_7EE7);
    send(0); send(0);
    check("R7 underflow sticky", underflow, 1);
    check("R4 pop count", pops_seen, pushes);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule